// File: doc/BRIEF.md
# Root Port Request Router

This block makes the routing decision for a root port that software sees as a PCI-to-PCI bridge. It accepts one configuration or memory request at a time. For each request it does one of four things. It claims the request and answers it locally. It passes the request downstream unchanged. It rewrites a type 1 configuration request as a type 0 request for the device on the far end of the link. Or it rejects the request. For every request it produces exactly one response to the upstream requester, carrying a status and read data.

Requests, downstream requests, downstream completions and upstream responses each use a valid/ready handshake. Once valid is raised it stays high, with its payload unchanged, until ready is seen in the same cycle. Holding ready low stalls the router. It never drops or reorders anything, and it does not accept a new request until the current response has been taken.

The configuration inputs are plain level signals, sampled when they are used:
- the secondary and subordinate bus numbers;
- two memory windows, each given as an inclusive base and limit;
- link state;
- retry-status visibility and the retry limit;
- the port's own bus, device and function numbers.

Software may change them only while no request is in flight. Local register accesses leave through a one-cycle strobe, and the register file behind that strobe lies outside this block.

Top module: `rr_root_router`

## Requirements
- R1: A configuration request of kind 2 (type 1), whose bus lies in the range sec_bus < bus <= sub_bus and whose link is up, is sent downstream as kind 2. Bus, device, function, address, write flag and write data are not changed.
- R2: A kind 2 request whose bus equals sec_bus is sent downstream as kind 1 (type 0) when its device number is 0 and the link is up. If its device number is not 0, it is never sent downstream and it completes locally as an absent device: status 0 (success), with data all ones for a read and zero for a write.
- R3: A kind 2 request whose bus is at most sec_bus-1 or above sub_bus is never sent downstream and completes with status 1 (Unsupported Request), with data all ones for a read and zero for a write.
- R4: Every kind 1 request is claimed by the port. It produces exactly one loc_en pulse, with loc_reg equal to address bits 11:2. It is never sent downstream. It completes with status 0 and data loc_rdata for a read, or zero for a write.
- R5: A kind 0 (memory) request whose address lies inclusively within either window is sent downstream when the link is up. A window whose base exceeds its limit claims nothing. A memory request outside both windows, or with the link down, is not sent downstream and completes with status 1, with data all ones for a read and zero for a write.
- R6: A configuration request that would go downstream while link_up is 0 is not sent. It completes with status 0, with data all ones for a read and zero for a write.
- R7: A downstream completion with status 1 gives status 0 and all-ones data for a configuration read. For a memory read it gives status 1 and all-ones data.
- R8: A downstream completion with status 0 gives status 0, with the completion data for a read and zero for a write. A forwarded memory write waits for no completion: it gets status 0 and zero data once it is accepted downstream.
- R9: A configuration completion with status 2 (retry), when crs_vis_en is 1, is passed up with status 2 and read data 0xFFFF_0001, and the request is not reissued.
- R10: A configuration completion with status 2, when crs_vis_en is 0, makes the port reissue the same request, up to retry_max extra times. Once those are used up and another status 2 arrives, the request completes with status 0 and all-ones read data.
- R11: dn_req_id and rsp_cpl_id are both equal to {own_bus, own_dev, own_fn}.
- R12: After reset req_ready is 1 and every other valid is 0. While a response or downstream request is held back by ready, its payload stays stable. No request is accepted while an earlier one is unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router can take a request |
| req_kind | input | 2 | 0 memory, 1 config type 0, 2 config type 1 |
| req_write | input | 1 | 1 for write |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_addr | input | AW | Memory address, or register byte offset for configuration |
| req_wdata | input | DW | Write data |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| np_base | input | AW | Non-prefetchable window base |
| np_limit | input | AW | Non-prefetchable window limit |
| pf_base | input | AW | Prefetchable window base |
| pf_limit | input | AW | Prefetchable window limit |
| link_up | input | 1 | Link is trained |
| crs_vis_en | input | 1 | Pass retry status to software |
| retry_max | input | RCW | Extra reissues allowed on retry status |
| own_bus | input | 8 | Port bus number |
| own_dev | input | 5 | Port device number |
| own_fn | input | 3 | Port function number |
| loc_en | output | 1 | Local register access strobe |
| loc_write | output | 1 | Local access is a write |
| loc_reg | output | 10 | Local register dword index |
| loc_wdata | output | DW | Local write data |
| loc_rdata | input | DW | Local read data, same cycle as loc_en |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts |
| dn_kind | output | 2 | Outgoing request kind |
| dn_write | output | 1 | Outgoing write flag |
| dn_bus | output | 8 | Outgoing bus |
| dn_dev | output | 5 | Outgoing device |
| dn_fn | output | 3 | Outgoing function |
| dn_addr | output | AW | Outgoing address |
| dn_wdata | output | DW | Outgoing write data |
| dn_req_id | output | 16 | Requester ID |
| cpl_valid | input | 1 | Downstream completion valid |
| cpl_ready | output | 1 | Router takes completion |
| cpl_status | input | 2 | 0 success, 1 unsupported, 2 retry |
| cpl_data | input | DW | Completion data |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_ready | input | 1 | Upstream takes response |
| rsp_status | output | 2 | 0 success, 1 unsupported, 2 retry |
| rsp_data | output | DW | Response data |
| rsp_cpl_id | output | 16 | Completer ID |

## Verification
Type 1 requests are driven with bus numbers:
- just inside the secondary-to-subordinate range and on each of its edges;
- just outside the range on both sides.

Together these separate forwarding, conversion and rejection. Memory addresses sit on a window base, on a limit, between the windows and inside a disabled window, which tells apart inclusive, exclusive and missing bounds. Downstream completions come back with each status, under both retry-visibility settings and with a retry that later succeeds. This separates pass-through, all-ones synthesis, visible retry and the reissue count. Link-down and held-off ready cases check that nothing leaks downstream and that payloads stay stable.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {RQ_MEM = 2'd0, RQ_CFG0 = 2'd1, RQ_CFG1 = 2'd2} rq_kind_e;
  typedef enum logic [1:0] {ST_SC = 2'd0, ST_UR = 2'd1, ST_CRS = 2'd2} cpl_stat_e;
  typedef enum logic [1:0] {ACT_LOCAL, ACT_FWD, ACT_UR, ACT_ONES} route_act_e;
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RESP} rr_state_e;
endpackage

// File: rtl/rr_window.sv
module rr_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          hit
);
  // A base above the limit means the window is switched off.
  assign hit = (base <= limit) && (addr >= base) && (addr <= limit);
endmodule

// File: rtl/rr_route.sv
module rr_route
  import rr_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [7:0] bus,
  input  logic [4:0] dev,
  input  logic [7:0] sec_bus,
  input  logic [7:0] sub_bus,
  input  logic       link_up,
  input  logic       win_hit,
  output route_act_e act,
  output rq_kind_e   fwd_kind
);
  always_comb begin
    act      = ACT_UR;
    fwd_kind = rq_kind_e'(kind);
    case (kind)
      RQ_CFG0: act = ACT_LOCAL;
      RQ_CFG1: begin
        if (bus == sec_bus) begin
          fwd_kind = RQ_CFG0;
          if (!link_up || dev != 5'd0) act = ACT_ONES;
          else                         act = ACT_FWD;
        end else if (bus > sec_bus && bus <= sub_bus) begin
          act = link_up ? ACT_FWD : ACT_ONES;
        end else begin
          act = ACT_UR;
        end
      end
      RQ_MEM: act = (win_hit && link_up) ? ACT_FWD : ACT_UR;
      default: act = ACT_UR;
    endcase
  end
endmodule

// File: rtl/rr_root_router.sv
module rr_root_router
  import rr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic           req_write,
  input  logic [7:0]     req_bus,
  input  logic [4:0]     req_dev,
  input  logic [2:0]     req_fn,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [7:0]     sec_bus,
  input  logic [7:0]     sub_bus,
  input  logic [AW-1:0]  np_base,
  input  logic [AW-1:0]  np_limit,
  input  logic [AW-1:0]  pf_base,
  input  logic [AW-1:0]  pf_limit,
  input  logic           link_up,
  input  logic           crs_vis_en,
  input  logic [RCW-1:0] retry_max,
  input  logic [7:0]     own_bus,
  input  logic [4:0]     own_dev,
  input  logic [2:0]     own_fn,
  output logic           loc_en,
  output logic           loc_write,
  output logic [9:0]     loc_reg,
  output logic [DW-1:0]  loc_wdata,
  input  logic [DW-1:0]  loc_rdata,
  output logic           dn_valid,
  input  logic           dn_ready,
  output logic [1:0]     dn_kind,
  output logic           dn_write,
  output logic [7:0]     dn_bus,
  output logic [4:0]     dn_dev,
  output logic [2:0]     dn_fn,
  output logic [AW-1:0]  dn_addr,
  output logic [DW-1:0]  dn_wdata,
  output logic [15:0]    dn_req_id,
  input  logic           cpl_valid,
  output logic           cpl_ready,
  input  logic [1:0]     cpl_status,
  input  logic [DW-1:0]  cpl_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [1:0]     rsp_status,
  output logic [DW-1:0]  rsp_data,
  output logic [15:0]    rsp_cpl_id
);
  localparam int NWIN = 2;
  localparam logic [DW-1:0] ONES     = '1;
  localparam logic [DW-1:0] CRS_DATA = {{(DW-16){1'b1}}, 16'h0001};

  rr_state_e      state;
  rq_kind_e       kind_q;
  logic           write_q;
  logic [7:0]     bus_q;
  logic [4:0]     dev_q;
  logic [2:0]     fn_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [RCW-1:0] retry_cnt;
  cpl_stat_e      stat_q;
  logic [DW-1:0]  data_q;

  logic [AW-1:0] wbase  [NWIN];
  logic [AW-1:0] wlimit [NWIN];
  logic [NWIN-1:0] win_hits;
  route_act_e act;
  rq_kind_e   fwd_kind;
  logic       accept;
  logic       is_cfg;
  logic [DW-1:0] fail_data;

  assign wbase[0]  = np_base;
  assign wlimit[0] = np_limit;
  assign wbase[1]  = pf_base;
  assign wlimit[1] = pf_limit;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    rr_window #(.AW(AW)) u_win (
      .addr (req_addr),
      .base (wbase[g]),
      .limit(wlimit[g]),
      .hit  (win_hits[g])
    );
  end

  rr_route u_route (
    .kind    (req_kind),
    .bus     (req_bus),
    .dev     (req_dev),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .link_up (link_up),
    .win_hit (|win_hits),
    .act     (act),
    .fwd_kind(fwd_kind)
  );

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign dn_valid  = (state == S_SEND);
  assign cpl_ready = (state == S_WAIT);
  assign rsp_valid = (state == S_RESP);

  assign loc_en    = accept && (act == ACT_LOCAL);
  assign loc_write = req_write;
  assign loc_reg   = req_addr[11:2];
  assign loc_wdata = req_wdata;

  assign dn_kind    = kind_q;
  assign dn_write   = write_q;
  assign dn_bus     = bus_q;
  assign dn_dev     = dev_q;
  assign dn_fn      = fn_q;
  assign dn_addr    = addr_q;
  assign dn_wdata   = wdata_q;
  assign dn_req_id  = {own_bus, own_dev, own_fn};
  assign rsp_cpl_id = {own_bus, own_dev, own_fn};
  assign rsp_status = stat_q;
  assign rsp_data   = data_q;

  assign is_cfg    = (kind_q != RQ_MEM);
  assign fail_data = write_q ? '0 : ONES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind_q    <= RQ_MEM;
      write_q   <= 1'b0;
      bus_q     <= '0;
      dev_q     <= '0;
      fn_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      retry_cnt <= '0;
      stat_q    <= ST_SC;
      data_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          kind_q    <= fwd_kind;
          write_q   <= req_write;
          bus_q     <= req_bus;
          dev_q     <= req_dev;
          fn_q      <= req_fn;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
          retry_cnt <= '0;
          case (act)
            ACT_LOCAL: begin
              stat_q <= ST_SC;
              data_q <= req_write ? '0 : loc_rdata;
              state  <= S_RESP;
            end
            ACT_UR: begin
              stat_q <= ST_UR;
              data_q <= req_write ? '0 : ONES;
              state  <= S_RESP;
            end
            ACT_ONES: begin
              stat_q <= ST_SC;
              data_q <= req_write ? '0 : ONES;
              state  <= S_RESP;
            end
            default: state <= S_SEND;
          endcase
        end
        S_SEND: if (dn_ready) begin
          if (kind_q == RQ_MEM && write_q) begin
            stat_q <= ST_SC;
            data_q <= '0;
            state  <= S_RESP;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (cpl_valid) begin
          if (cpl_stat_e'(cpl_status) == ST_SC) begin
            stat_q <= ST_SC;
            data_q <= write_q ? '0 : cpl_data;
            state  <= S_RESP;
          end else if (cpl_stat_e'(cpl_status) == ST_CRS && is_cfg) begin
            if (crs_vis_en) begin
              stat_q <= ST_CRS;
              data_q <= write_q ? '0 : CRS_DATA;
              state  <= S_RESP;
            end else if (retry_cnt < retry_max) begin
              retry_cnt <= retry_cnt + 1'b1;
              state     <= S_SEND;
            end else begin
              stat_q <= ST_SC;
              data_q <= fail_data;
              state  <= S_RESP;
            end
          end else begin
            stat_q <= is_cfg ? ST_SC : ST_UR;
            data_q <= fail_data;
            state  <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rr_root_router_chk.sv
module rr_root_router_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RCW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [7:0]    sec_bus,
  input logic [7:0]    sub_bus,
  input logic [AW-1:0] np_base,
  input logic [AW-1:0] np_limit,
  input logic [AW-1:0] pf_base,
  input logic [AW-1:0] pf_limit,
  input logic          crs_vis_en,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic [1:0]    dn_kind,
  input logic [7:0]    dn_bus,
  input logic [4:0]    dn_dev,
  input logic [AW-1:0] dn_addr,
  input logic          cpl_valid,
  input logic          cpl_ready,
  input logic [1:0]    cpl_status,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_status,
  input logic [DW-1:0] rsp_data
);
  logic np_in, pf_in;
  assign np_in = (np_base <= np_limit) && (dn_addr >= np_base) && (dn_addr <= np_limit);
  assign pf_in = (pf_base <= pf_limit) && (dn_addr >= pf_base) && (dn_addr <= pf_limit);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));

  assert_dn_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_bus) && $stable(dn_kind));

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || dn_valid || cpl_ready) |-> !req_ready);

  assert_type1_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'd2 |-> dn_bus > sec_bus && dn_bus <= sub_bus);

  assert_type0_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'd1 |-> dn_bus == sec_bus && dn_dev == 5'd0);

  assert_mem_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'd0 |-> np_in || pf_in);

  assert_crs_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_ready && cpl_status == 2'd2 && crs_vis_en && dn_kind != 2'd0
    |=> rsp_valid && rsp_status == 2'd2);
endmodule

bind rr_root_router rr_root_router_chk #(.AW(AW), .DW(DW), .RCW(RCW)) u_chk (.*);

// File: tb/tb_rr_root_router.sv
`timescale 1ns/1ps
module tb_rr_root_router;
  localparam int AW = 32, DW = 32, RCW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_bus = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_fn = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [7:0] sec_bus = 8'd2, sub_bus = 8'd5;
  logic [AW-1:0] np_base = 32'h4000_0000, np_limit = 32'h4FFF_FFFF;
  logic [AW-1:0] pf_base = 32'h8000_0000, pf_limit = 32'h8FFF_FFFF;
  logic link_up = 1, crs_vis_en = 0;
  logic [RCW-1:0] retry_max = 4'd2;
  logic [7:0] own_bus = 8'd0;
  logic [4:0] own_dev = 5'd1;
  logic [2:0] own_fn = 3'd0;
  logic loc_en, loc_write;
  logic [9:0] loc_reg;
  logic [DW-1:0] loc_wdata, loc_rdata;
  logic dn_valid, dn_ready = 0, dn_write;
  logic [1:0] dn_kind;
  logic [7:0] dn_bus;
  logic [4:0] dn_dev;
  logic [2:0] dn_fn;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [15:0] dn_req_id;
  logic cpl_valid = 0, cpl_ready;
  logic [1:0] cpl_status = 0;
  logic [DW-1:0] cpl_data = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [1:0] rsp_status;
  logic [DW-1:0] rsp_data;
  logic [15:0] rsp_cpl_id;

  assign loc_rdata = {16'hC0DE, 6'd0, loc_reg};

  rr_root_router #(.AW(AW), .DW(DW), .RCW(RCW)) dut (.*);

  int checks = 0, errors = 0, dn_count = 0, loc_count = 0;
  logic [9:0] loc_last = 0;
  localparam logic [15:0] MY_ID = 16'h0008;

  always @(posedge clk) begin
    if (rst_n && dn_valid && dn_ready) dn_count <= dn_count + 1;
    if (rst_n && loc_en) begin loc_count <= loc_count + 1; loc_last <= loc_reg; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [1:0] k, input logic w, input logic [7:0] b,
                          input logic [4:0] d, input logic [2:0] f,
                          input logic [31:0] a, input logic [31:0] wd);
    int n = 0;
    req_kind = k; req_write = w; req_bus = b; req_dev = d; req_fn = f;
    req_addr = a; req_wdata = wd; req_valid = 1;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic dn_take(input string tag, input logic [1:0] k, input logic [7:0] b,
                         input logic [4:0] d, input logic [31:0] a);
    int n = 0;
    while (!dn_valid && n < 100) begin @(negedge clk); n++; end
    chk({tag, " dn_valid"}, dn_valid, 1);
    chk({tag, " dn_kind"}, dn_kind, k);
    chk({tag, " dn_bus"}, dn_bus, b);
    chk({tag, " dn_dev"}, dn_dev, d);
    chk({tag, " dn_addr"}, dn_addr, a);
    chk({tag, " R11 req_id"}, dn_req_id, MY_ID);
    dn_ready = 1;
    @(negedge clk);
    dn_ready = 0;
  endtask

  task automatic give_cpl(input logic [1:0] st, input logic [31:0] d);
    int n = 0;
    cpl_status = st; cpl_data = d; cpl_valid = 1;
    while (!cpl_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    cpl_valid = 0;
  endtask

  task automatic get_rsp(input string tag, input logic [1:0] st, input logic [31:0] d,
                         input int hold);
    int n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    repeat (hold) @(negedge clk);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_status"}, rsp_status, st);
    chk({tag, " rsp_data"}, rsp_data, d);
    chk({tag, " R11 cpl_id"}, rsp_cpl_id, MY_ID);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset();
    chk("R12 reset req_ready", req_ready, 1);
    chk("R12 reset dn_valid", dn_valid, 0);
    chk("R12 reset rsp_valid", rsp_valid, 0);
    chk("R12 reset cpl_ready", cpl_ready, 0);
  endtask

  task automatic t_type1_forward();
    send_req(2'd2, 0, 8'd4, 5'd3, 3'd1, 32'h10, 0);
    chk("R12 busy blocks req", req_ready, 0);
    dn_take("R1 bus4", 2'd2, 8'd4, 5'd3, 32'h10);
    give_cpl(2'd0, 32'h1234_5678);
    get_rsp("R8 bus4 read", 2'd0, 32'h1234_5678, 3);
    send_req(2'd2, 0, 8'd5, 5'd7, 3'd0, 32'h20, 0);
    dn_take("R1 bus5 sub edge", 2'd2, 8'd5, 5'd7, 32'h20);
    give_cpl(2'd0, 32'hAAAA_0001);
    get_rsp("R8 bus5", 2'd0, 32'hAAAA_0001, 0);
  endtask

  task automatic t_type0_convert();
    int c;
    send_req(2'd2, 0, 8'd2, 5'd0, 3'd2, 32'h4, 0);
    dn_take("R2 convert", 2'd1, 8'd2, 5'd0, 32'h4);
    give_cpl(2'd0, 32'h0000_BEEF);
    get_rsp("R2 convert rsp", 2'd0, 32'h0000_BEEF, 0);
    c = dn_count;
    send_req(2'd2, 0, 8'd2, 5'd1, 3'd0, 32'h0, 0);
    get_rsp("R2 absent dev", 2'd0, 32'hFFFF_FFFF, 0);
    chk("R2 absent not forwarded", dn_count, c);
  endtask

  task automatic t_out_of_range();
    int c = dn_count;
    send_req(2'd2, 0, 8'd6, 5'd0, 3'd0, 32'h0, 0);
    get_rsp("R3 bus above sub", 2'd1, 32'hFFFF_FFFF, 0);
    send_req(2'd2, 1, 8'd1, 5'd0, 3'd0, 32'h0, 32'h55);
    get_rsp("R3 bus below sec write", 2'd1, 32'h0, 0);
    chk("R3 not forwarded", dn_count, c);
  endtask

  task automatic t_local();
    int c = dn_count, l = loc_count;
    send_req(2'd1, 0, 8'd9, 5'd9, 3'd0, 32'h0C, 0);
    get_rsp("R4 local read", 2'd0, {16'hC0DE, 6'd0, 10'd3}, 0);
    chk("R4 loc pulses", loc_count, l + 1);
    chk("R4 loc reg", loc_last, 10'd3);
    chk("R4 not forwarded", dn_count, c);
  endtask

  task automatic t_memory();
    int c;
    send_req(2'd0, 0, 0, 0, 0, 32'h4000_0000, 0);
    dn_take("R5 np base", 2'd0, 8'd0, 5'd0, 32'h4000_0000);
    give_cpl(2'd0, 32'hFACE_0000);
    get_rsp("R5 np read", 2'd0, 32'hFACE_0000, 0);
    send_req(2'd0, 1, 0, 0, 0, 32'h8FFF_FFFF, 32'h77);
    dn_take("R5 pf limit write", 2'd0, 8'd0, 5'd0, 32'h8FFF_FFFF);
    get_rsp("R8 posted write", 2'd0, 32'h0, 2);
    c = dn_count;
    send_req(2'd0, 0, 0, 0, 0, 32'h5000_0000, 0);
    get_rsp("R5 miss", 2'd1, 32'hFFFF_FFFF, 0);
    np_base = 32'h5000_0000; np_limit = 32'h4000_0000;
    send_req(2'd0, 0, 0, 0, 0, 32'h4800_0000, 0);
    get_rsp("R5 disabled window", 2'd1, 32'hFFFF_FFFF, 0);
    np_base = 32'h4000_0000; np_limit = 32'h4FFF_FFFF;
    chk("R5 misses not forwarded", dn_count, c);
  endtask

  task automatic t_link_down();
    int c = dn_count;
    link_up = 0;
    send_req(2'd2, 0, 8'd3, 5'd0, 3'd0, 32'h0, 0);
    get_rsp("R6 link down cfg", 2'd0, 32'hFFFF_FFFF, 0);
    send_req(2'd0, 0, 0, 0, 0, 32'h4000_0100, 0);
    get_rsp("R5 link down mem", 2'd1, 32'hFFFF_FFFF, 0);
    chk("R6 not forwarded", dn_count, c);
    link_up = 1;
  endtask

  task automatic t_downstream_ur();
    send_req(2'd2, 0, 8'd3, 5'd0, 3'd0, 32'h0, 0);
    dn_take("R7 cfg", 2'd2, 8'd3, 5'd0, 32'h0);
    give_cpl(2'd1, 32'h0);
    get_rsp("R7 cfg UR", 2'd0, 32'hFFFF_FFFF, 0);
    send_req(2'd0, 0, 0, 0, 0, 32'h8000_0040, 0);
    dn_take("R7 mem", 2'd0, 8'd0, 5'd0, 32'h8000_0040);
    give_cpl(2'd1, 32'h0);
    get_rsp("R7 mem UR", 2'd1, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_crs_visible();
    int c = dn_count;
    crs_vis_en = 1;
    send_req(2'd2, 0, 8'd4, 5'd0, 3'd0, 32'h0, 0);
    dn_take("R9 send", 2'd2, 8'd4, 5'd0, 32'h0);
    give_cpl(2'd2, 32'h0);
    get_rsp("R9 crs visible", 2'd2, 32'hFFFF_0001, 0);
    chk("R9 single send", dn_count, c + 1);
    crs_vis_en = 0;
  endtask

  task automatic t_crs_retry();
    int c = dn_count;
    for (int i = 0; i < 3; i++) begin
      if (i == 0) send_req(2'd2, 0, 8'd4, 5'd2, 3'd0, 32'h8, 0);
      dn_take("R10 retry send", 2'd2, 8'd4, 5'd2, 32'h8);
      give_cpl(2'd2, 32'h0);
    end
    get_rsp("R10 exhausted", 2'd0, 32'hFFFF_FFFF, 0);
    chk("R10 send count", dn_count, c + 3);
    send_req(2'd2, 0, 8'd3, 5'd0, 3'd0, 32'h0, 0);
    dn_take("R10 first", 2'd2, 8'd3, 5'd0, 32'h0);
    give_cpl(2'd2, 32'h0);
    dn_take("R10 reissue", 2'd2, 8'd3, 5'd0, 32'h0);
    give_cpl(2'd0, 32'h0000_ABCD);
    get_rsp("R10 retry success", 2'd0, 32'h0000_ABCD, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_type1_forward();
    t_type0_convert();
    t_out_of_range();
    t_local();
    t_memory();
    t_link_down();
    t_downstream_ur();
    t_crs_visible();
    t_crs_retry();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule